// File: doc/BRIEF.md
# Synchronizable Integer Clock Divider

This block turns a fast input clock into a slower sampling clock by a programmable whole-number ratio from 1 to 8. It also gives a one-cycle phase-zero marker at the start of every output period. Several copies of the block can be lined up by a shared external SYNC pulse. A detected SYNC forces the internal counter back to its starting point, so every copy starts its next output period on the same input edge.

Software writes the settings with a single write strobe. The settings are the ratio, an enable for SYNC realignment, a mode bit and a duty-correction bit. The mode bit chooses between two behaviours: obey every SYNC, or obey only the first SYNC after the most recent write. For odd ratios, the duty-correction bit lets the high phase last an extra half input period. It does this by using the falling edge of the input clock, which brings the duty cycle to 50%.

Top module: `syncdiv`

## Requirements
- R1: After reset the active ratio is 1 and duty correction is on. SYNC realignment is disabled, one-shot mode is selected and the one-shot latch is armed. While reset is held and in the first cycle after it, `clk_div` and `phase0` are both 1.
- R2: `cfg_ratio` holds N-1, so values 0..7 select N = 1..8. All settings are captured on a rising edge where `cfg_wr` is 1. Each output period then lasts N input cycles.
- R3: For an even N, `clk_div` is high for the first N/2 cycles of the period and low for the remaining N/2. The high phase always begins in the phase-zero cycle.
- R4: For an odd N > 1 with `cfg_duty_fix`=1, `clk_div` is high for (N-1)/2 cycles plus the first half of the next cycle. With `cfg_duty_fix`=0 it is high for exactly (N-1)/2 cycles. For N = 1, `clk_div` stays high.
- R5: A newly written ratio or duty setting is used only from the next phase-zero cycle. The running period always completes, so no runt pulse appears.
- R6: `phase0` is 1 exactly in the cycles where the counter is at its starting value. With N = 1 that is every cycle.
- R7: `sync_in` is sampled on rising edges, and only a 0-to-1 change counts as an event. Suppose `sync_in` is first seen high at edge k and the event is accepted. The counter is then at phase zero after edge k+1. A level held high causes only one realignment.
- R8: With SYNC realignment disabled (`cfg_sync_en`=0), SYNC events leave the output sequence unchanged.
- R9: In one-shot mode (`cfg_sync_every`=0), only the first SYNC event after a write is accepted. Later events are ignored until `cfg_wr` is pulsed again.
- R10: In every-SYNC mode (`cfg_sync_every`=1), each SYNC event realigns the counter.
- R11: An accepted SYNC also applies the most recently written ratio and duty setting at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_in | input | 1 | Fast input clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_wr | input | 1 | Configuration write strobe; also re-arms one-shot SYNC |
| cfg_ratio | input | RATIO_W (3) | Divide ratio minus one |
| cfg_sync_en | input | 1 | Enables realignment on SYNC |
| cfg_sync_every | input | 1 | 1: obey every SYNC; 0: only the first after a write |
| cfg_duty_fix | input | 1 | Half-cycle extension of the high phase for odd ratios |
| sync_in | input | 1 | External alignment pulse |
| clk_div | output | 1 | Divided clock |
| phase0 | output | 1 | High in the cycle where the counter is at phase zero |

## Verification
A reference model in the bench advances on the same rising edge as the design's registers. The model pushes the expected phase marker and the expected divided-clock levels for the cycle that edge starts. A monitor pops these values and compares them with samples taken a quarter and three quarters into that cycle.

A configuration write therefore appears only at the next phase-zero cycle of the model. A SYNC driven before edge k shows its realignment in the cycle after edge k+1. The half-cycle extension for odd ratios is seen only in the early sample of the cycle after the high phase ends.

// File: rtl/syncdiv.sv
module syncdiv #(
  parameter int RATIO_W = 3
) (
  input  logic               clk_in,
  input  logic               rst_n,
  input  logic               cfg_wr,
  input  logic [RATIO_W-1:0] cfg_ratio,
  input  logic               cfg_sync_en,
  input  logic               cfg_sync_every,
  input  logic               cfg_duty_fix,
  input  logic               sync_in,
  output logic               clk_div,
  output logic               phase0
);

  localparam int NW = RATIO_W + 1;
  localparam logic [NW-1:0] ONE = NW'(1);

  logic [RATIO_W-1:0] cnt, cnt_nxt;
  logic [NW-1:0]      pend_n, act_n, act_nxt;
  logic               pend_fix, act_fix, act_fix_nxt;
  logic               sync_on, sync_every, armed;
  logic               sync_q, sync_d;
  logic               hi_q, hi_nxt, lo_q;

  wire sync_rise = sync_q & ~sync_d;
  wire take      = sync_rise & sync_on & (sync_every | armed);
  wire wrap      = ({1'b0, cnt} == act_n - ONE);

  always_comb begin
    if (take || wrap) begin
      cnt_nxt     = '0;
      act_nxt     = pend_n;
      act_fix_nxt = pend_fix;
    end else begin
      cnt_nxt     = cnt + 1'b1;
      act_nxt     = act_n;
      act_fix_nxt = act_fix;
    end
  end

  assign hi_nxt = (act_nxt == ONE) | ({1'b0, cnt_nxt} < (act_nxt >> 1));

  always_ff @(posedge clk_in or negedge rst_n) begin
    if (!rst_n) begin
      cnt        <= '0;
      act_n      <= ONE;
      act_fix    <= 1'b1;
      pend_n     <= ONE;
      pend_fix   <= 1'b1;
      sync_on    <= 1'b0;
      sync_every <= 1'b0;
      armed      <= 1'b1;
      sync_q     <= 1'b0;
      sync_d     <= 1'b0;
      hi_q       <= 1'b1;
    end else begin
      cnt     <= cnt_nxt;
      act_n   <= act_nxt;
      act_fix <= act_fix_nxt;
      hi_q    <= hi_nxt;
      sync_q  <= sync_in;
      sync_d  <= sync_q;
      if (cfg_wr) begin
        pend_n     <= {1'b0, cfg_ratio} + ONE;
        pend_fix   <= cfg_duty_fix;
        sync_on    <= cfg_sync_en;
        sync_every <= cfg_sync_every;
        armed      <= 1'b1;
      end else if (take && !sync_every) begin
        armed <= 1'b0;
      end
    end
  end

  always_ff @(negedge clk_in or negedge rst_n) begin
    if (!rst_n) lo_q <= 1'b0;
    else        lo_q <= hi_q;
  end

  assign clk_div = hi_q | (act_n[0] & act_fix & lo_q);
  assign phase0  = (cnt == '0);

  // R7
  sync_align_chk: assert property (@(posedge clk_in) disable iff (!rst_n)
    take |=> phase0);

  // R9
  oneshot_disarm_chk: assert property (@(posedge clk_in) disable iff (!rst_n)
    (take && !sync_every && !cfg_wr) |=> !armed);

  // R5
  ratio_boundary_chk: assert property (@(posedge clk_in) disable iff (!rst_n)
    !$stable(act_n) |-> phase0);

  // R2
  cnt_range_chk: assert property (@(posedge clk_in) disable iff (!rst_n)
    {1'b0, cnt} < act_n);

  // R3
  high_start_chk: assert property (@(posedge clk_in) disable iff (!rst_n)
    $rose(hi_q) |-> phase0);

  // R6
  unity_ratio_chk: assert property (@(posedge clk_in) disable iff (!rst_n)
    (act_n == ONE) |-> (phase0 && clk_div));

endmodule

// File: tb/syncdiv_tb.sv
module syncdiv_tb;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic       rst_n = 1'b0;
  logic       cfg_wr = 1'b0;
  logic [2:0] cfg_ratio = 3'd0;
  logic       cfg_sync_en = 1'b0;
  logic       cfg_sync_every = 1'b0;
  logic       cfg_duty_fix = 1'b1;
  logic       sync_in = 1'b0;
  logic       clk_div, phase0;

  syncdiv #(.RATIO_W(3)) u_dut (
    .clk_in(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_ratio(cfg_ratio),
    .cfg_sync_en(cfg_sync_en), .cfg_sync_every(cfg_sync_every),
    .cfg_duty_fix(cfg_duty_fix), .sync_in(sync_in),
    .clk_div(clk_div), .phase0(phase0)
  );

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;
  string cur_tag = "R1";

  logic [2:0] exp_q[$];
  string      tag_q[$];

  // reference model state
  int m_cnt = 0, m_act = 1, m_pend = 1;
  bit m_fixa = 1, m_pfix = 1, m_en = 0, m_every = 0, m_armed = 1;
  bit m_sq = 0, m_sd = 0, m_hprev = 0;

  function automatic bit hi_of(int c, int n);
    return (n == 1) || (c < n / 2);
  endfunction

  task automatic model_step();
    bit take, hp, h, c1;
    take = m_sq && !m_sd && m_en && (m_every || m_armed);
    hp = hi_of(m_cnt, m_act);
    if (take || m_cnt == m_act - 1) begin
      m_cnt = 0; m_act = m_pend; m_fixa = m_pfix;
    end else m_cnt++;
    if (cfg_wr) begin
      m_armed = 1; m_pend = int'(cfg_ratio) + 1; m_pfix = cfg_duty_fix;
      m_en = cfg_sync_en; m_every = cfg_sync_every;
    end else if (take && !m_every) m_armed = 0;
    m_sd = m_sq; m_sq = sync_in; m_hprev = hp;
    h  = hi_of(m_cnt, m_act);
    c1 = h | ((m_act % 2 == 1) && m_fixa && m_hprev);
    exp_q.push_back({m_cnt == 0, c1, h});
    tag_q.push_back(cur_tag);
  endtask

  task automatic tick(int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      model_step();
      #12;
    end
  endtask

  task automatic write_cfg(int ratio, bit fix, bit en, bit every);
    cfg_ratio = 3'(ratio - 1); cfg_duty_fix = fix;
    cfg_sync_en = en; cfg_sync_every = every; cfg_wr = 1'b1;
    tick();
    cfg_wr = 1'b0;
  endtask

  task automatic pulse_sync(int len = 1);
    sync_in = 1'b1;
    tick(len);
    sync_in = 1'b0;
  endtask

  // monitor: pops one expected item per cycle and compares
  initial begin
    logic p, s1, s2;
    logic [2:0] e;
    string t;
    forever begin
      @(posedge clk);
      #5; p = phase0; s1 = clk_div;
      #10; s2 = clk_div;
      if (exp_q.size() > 0) begin
        e = exp_q.pop_front(); t = tag_q.pop_front();
        checks++;
        if ({p, s1, s2} !== e) begin
          failures++;
          $display("FAIL %s: {phase0,clk_early,clk_late} actual=%b expected=%b at %0t",
                   t, {p, s1, s2}, e, $time);
        end
      end
    end
  end

  initial begin
    #(20 * 20000);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #12;
    checks++;
    if ({phase0, clk_div} !== 2'b11) begin
      failures++;
      $display("FAIL R1: reset outputs actual=%b expected=11", {phase0, clk_div});
    end
    rst_n = 1'b1;

    cur_tag = "R1 R6"; tick(6);

    cur_tag = "R2 R3"; write_cfg(4, 1, 0, 0); tick(16);
    cur_tag = "R3";    write_cfg(8, 1, 0, 0); tick(20);
    cur_tag = "R3";    write_cfg(2, 0, 0, 0); tick(10);
    cur_tag = "R4";    write_cfg(5, 1, 0, 0); tick(16);
    cur_tag = "R4";    write_cfg(5, 0, 0, 0); tick(16);
    cur_tag = "R4";    write_cfg(3, 1, 0, 0); tick(12);
    cur_tag = "R4";    write_cfg(7, 0, 0, 0); tick(16);
    cur_tag = "R4";    write_cfg(1, 1, 0, 0); tick(6);

    cur_tag = "R5"; write_cfg(6, 1, 0, 0); tick(7);
    write_cfg(2, 1, 0, 0); tick(12);

    cur_tag = "R8"; write_cfg(8, 1, 0, 0); tick(11);
    pulse_sync(); tick(10);

    cur_tag = "R9"; write_cfg(8, 1, 1, 0); tick(4);
    pulse_sync(); tick(5);
    pulse_sync(); tick(6);
    write_cfg(8, 1, 1, 0); tick(2);
    pulse_sync(); tick(9);

    cur_tag = "R10"; write_cfg(7, 1, 1, 1); tick(10);
    pulse_sync(); tick(3);
    pulse_sync(); tick(4);
    pulse_sync(); tick(8);

    cur_tag = "R7"; tick(2); pulse_sync(12); tick(10);

    cur_tag = "R11"; write_cfg(8, 1, 1, 1); tick(11);
    write_cfg(3, 1, 1, 1); pulse_sync(); tick(12);

    tick(2);
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule